// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sequences a small microcontroller into and out of its low-power states. Software arms a sleep-enable bit and issues a one-cycle sleep request with a 3-bit mode code. The controller then removes the clock enables of the domains that the selected mode shuts down. The domains are CPU, flash, I/O, ADC and the asynchronous timer. In the deepest modes it also raises a stop line for the external oscillator.

While asleep, the block compares a vector of wake events against a mask that depends on the mode. The first event the mode accepts ends sleep. A level-type wake line is filtered so that only a level held for two consecutive clocks counts. The two modes that stop the oscillator do not release the clocks at once. They first run a wake-up delay, with the oscillator restarted and the clocks still gated. The length of that delay comes from a small configuration field that is shared with the reset time-out. Entering the two light modes while the ADC is on issues a single-cycle conversion start.

Top module: `sleep_clock_ctrl`

## Requirements
- R1: A sleep request taken while `sleep_en` is low has no effect: every clock enable stays high and `osc_stop` stays low.
- R2: Mode code 000 (light sleep) drives the CPU and flash enables low, keeps the I/O, ADC and async-timer enables high, and keeps `osc_stop` low. All outputs change on the clock edge that samples the request.
- R3: In light sleep, any wake event ends sleep, including the generic-interrupt event at `wake_evt[0]`.
- R4: Mode code 001 (ADC quiet) drives the CPU, flash and I/O enables low, keeps the ADC and async-timer enables high, and keeps `osc_stop` low.
- R5: In ADC quiet, only `wake_evt[1]` through `wake_evt[9]` end sleep; the generic interrupt `wake_evt[0]` is ignored. The bit meanings are: 1 conversion done, 2 external reset, 3 watchdog reset, 4 brown-out reset, 5 two-wire address match, 6 async-timer interrupt, 7 memory ready, 8 upper external level line, 9 lower external interrupt lines.
- R6: `adc_start` pulses high for exactly one cycle, on the edge that enters code 000 or 001, and only if `adc_on` is high. It stays low when entering codes 010 or 011.
- R7: Mode code 010 (deep stop) drives every clock enable low and raises `osc_stop`.
- R8: In deep stop, only `wake_evt[2]`, `[3]`, `[4]`, `[5]`, `[8]` and `[9]` end sleep. Bits 0, 1, 6 and 7 are ignored.
- R9: After a wake from code 010 or 011, `osc_stop` falls on the wake edge. The mode's clock gating then holds for exactly 4·2^`dly_cfg` cycles, after which all enables return high.
- R10: Mode code 011 (timer save) behaves like deep stop, except that the async-timer enable stays high and `wake_evt[6]` is an additional accepted wake source.
- R11: Mode codes 100 to 111 behave exactly like code 000: the same gating, the same wake sources, the same conversion start, and no wake-up delay.
- R12: `wake_evt[8]` wakes the block only after it has been sampled high on two consecutive clock edges; a single-cycle high is ignored.
- R13: A wake from codes 000 or 001 restores every clock enable on the same edge that samples the wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_en | input | 1 | Arms sleep; requests are ignored while low |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| mode_sel | input | 3 | Sleep mode code |
| adc_on | input | 1 | ADC is enabled; allows an automatic conversion start |
| dly_cfg | input | DLY_W (3) | Wake-up delay select, 4·2^value cycles |
| wake_evt | input | 10 | Wake event vector, bit meanings in R5 |
| clk_en_cpu | output | 1 | CPU domain clock enable |
| clk_en_flash | output | 1 | Flash domain clock enable |
| clk_en_io | output | 1 | I/O domain clock enable |
| clk_en_adc | output | 1 | ADC domain clock enable |
| clk_en_async | output | 1 | Asynchronous timer domain clock enable |
| osc_stop | output | 1 | Stops the external oscillator |
| adc_start | output | 1 | One-cycle conversion start on sleep entry |

## Verification
The hardest situation to reach from the ports is the last cycle of the wake-up delay. The clocks must still be gated one cycle before release and must open on exactly the next edge, at two different delay settings. The stimulus enters deep stop and timer save, fires an accepted event, then steps one clock at a time and compares the whole gate vector at every boundary. Ignored wake sources are fired one by one before the accepted one, so that each of them is seen to leave the gating unchanged.

// File: rtl/slp_pkg.sv
package slp_pkg;

  localparam int WAKE_N = 10;

  // wake event bit positions
  localparam int WK_IRQ   = 0;
  localparam int WK_ADC   = 1;
  localparam int WK_XRST  = 2;
  localparam int WK_WRST  = 3;
  localparam int WK_BROWN = 4;
  localparam int WK_TWI   = 5;
  localparam int WK_ATMR  = 6;
  localparam int WK_MEM   = 7;
  localparam int WK_LVL   = 8;
  localparam int WK_EXT   = 9;

  typedef enum logic [1:0] {
    M_LIGHT = 2'd0,
    M_QUIET = 2'd1,
    M_DEEP  = 2'd2,
    M_SAVE  = 2'd3
  } slp_mode_e;

  typedef enum logic [1:0] {
    S_RUN   = 2'd0,
    S_SLEEP = 2'd1,
    S_DLY   = 2'd2
  } slp_state_e;

  // map the software code to a mode; unknown codes fall back to light sleep
  function automatic slp_mode_e code_to_mode(logic [2:0] code);
    slp_mode_e m;
    case (code)
      3'b001:  m = M_QUIET;
      3'b010:  m = M_DEEP;
      3'b011:  m = M_SAVE;
      default: m = M_LIGHT;
    endcase
    return m;
  endfunction

  function automatic logic mode_is_deep(slp_mode_e m);
    return (m == M_DEEP) || (m == M_SAVE);
  endfunction

  function automatic logic mode_starts_adc(slp_mode_e m);
    return (m == M_LIGHT) || (m == M_QUIET);
  endfunction

  // which wake events each mode accepts
  function automatic logic [WAKE_N-1:0] wake_mask(slp_mode_e m);
    logic [WAKE_N-1:0] k;
    k = '0;
    k[WK_XRST]  = 1'b1;
    k[WK_WRST]  = 1'b1;
    k[WK_BROWN] = 1'b1;
    k[WK_TWI]   = 1'b1;
    k[WK_LVL]   = 1'b1;
    k[WK_EXT]   = 1'b1;
    case (m)
      M_LIGHT: k = '1;
      M_QUIET: begin
        k[WK_ADC]  = 1'b1;
        k[WK_ATMR] = 1'b1;
        k[WK_MEM]  = 1'b1;
      end
      M_SAVE:  k[WK_ATMR] = 1'b1;
      default: ;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import slp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAKE_N-1:0] wake_evt,
  input  slp_mode_e         mode_q,
  output logic              wake_hit
);

  logic              lvl_q;
  logic              lvl_ok;
  logic [WAKE_N-1:0] qualified;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= wake_evt[WK_LVL];
  end

  assign lvl_ok = wake_evt[WK_LVL] & lvl_q;

  always_comb begin
    qualified         = wake_evt;
    qualified[WK_LVL] = lvl_ok;
  end

  assign wake_hit = |(qualified & wake_mask(mode_q));

  // R12: level line only counts once it was also high on the previous edge
  assert_level_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_ok |-> $past(wake_evt[WK_LVL]));

endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
  parameter int DLY_W        = 3,
  parameter int DLY_BASE_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             done
);

  localparam int CNT_W = DLY_BASE_LOG + (1 << DLY_W);

  logic [CNT_W-1:0] cnt;

  // delay length in cycles: 2^(base + cfg)
  function automatic logic [CNT_W-1:0] dly_len(logic [DLY_W-1:0] c);
    return CNT_W'(1) << (DLY_BASE_LOG + int'(c));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= dly_len(dly_cfg) - CNT_W'(1);
    else if (run && cnt != '0) cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);

  // R9: the counter moves down by one every running cycle
  assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !done) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_en,
  input  logic       sleep_req,
  input  logic [2:0] mode_sel,
  input  logic       adc_on,
  input  logic       wake_hit,
  input  logic       dly_done,
  output slp_state_e state,
  output slp_mode_e  mode_q,
  output logic       dly_load,
  output logic       adc_start
);

  slp_state_e state_nx;
  logic       enter;
  slp_mode_e  mode_nx;

  assign enter    = (state == S_RUN) && sleep_req && sleep_en;
  assign mode_nx  = code_to_mode(mode_sel);
  assign dly_load = (state == S_SLEEP) && wake_hit && mode_is_deep(mode_q);

  always_comb begin
    state_nx = state;
    case (state)
      S_RUN:   if (enter) state_nx = S_SLEEP;
      S_SLEEP: if (wake_hit) state_nx = mode_is_deep(mode_q) ? S_DLY : S_RUN;
      S_DLY:   if (dly_done) state_nx = S_RUN;
      default: state_nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RUN;
      mode_q    <= M_LIGHT;
      adc_start <= 1'b0;
    end else begin
      state     <= state_nx;
      adc_start <= enter && adc_on && mode_starts_adc(mode_nx);
      if (enter) mode_q <= mode_nx;
    end
  end

  // R1: a request without the arm bit leaves the controller running
  assert_unarmed_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && !sleep_en) |=> (state == S_RUN));

  // R6: conversion start lasts a single cycle
  assert_adc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R13: light modes return to run on the wake edge itself
  assert_fast_wake_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SLEEP && wake_hit && !mode_is_deep(mode_q)) |=> (state == S_RUN));

endmodule

// File: rtl/slp_clk_decode.sv
module slp_clk_decode
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_e state,
  input  slp_mode_e  mode_q,
  output logic       clk_en_cpu,
  output logic       clk_en_flash,
  output logic       clk_en_io,
  output logic       clk_en_adc,
  output logic       clk_en_async,
  output logic       osc_stop
);

  logic gated;

  assign gated = (state != S_RUN);

  always_comb begin
    clk_en_cpu   = 1'b1;
    clk_en_flash = 1'b1;
    clk_en_io    = 1'b1;
    clk_en_adc   = 1'b1;
    clk_en_async = 1'b1;
    osc_stop     = 1'b0;
    if (gated) begin
      clk_en_cpu   = 1'b0;
      clk_en_flash = 1'b0;
      case (mode_q)
        M_QUIET: clk_en_io = 1'b0;
        M_DEEP: begin
          clk_en_io    = 1'b0;
          clk_en_adc   = 1'b0;
          clk_en_async = 1'b0;
        end
        M_SAVE: begin
          clk_en_io  = 1'b0;
          clk_en_adc = 1'b0;
        end
        default: ;
      endcase
      osc_stop = (state == S_SLEEP) && mode_is_deep(mode_q);
    end
  end

  // R7: a stopped oscillator never coexists with a running synchronous domain
  assert_osc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> !(clk_en_cpu || clk_en_flash || clk_en_io || clk_en_adc));

  // R9: during the wake-up delay the oscillator runs but the CPU stays gated
  assert_delay_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DLY) |-> (!osc_stop && !clk_en_cpu));

  // R2: CPU and flash are always gated together
  assert_cpu_flash_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_cpu == clk_en_flash);

endmodule

// File: rtl/sleep_clock_ctrl.sv
module sleep_clock_ctrl
  import slp_pkg::*;
#(
  parameter int DLY_W        = 3,
  parameter int DLY_BASE_LOG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_en,
  input  logic              sleep_req,
  input  logic [2:0]        mode_sel,
  input  logic              adc_on,
  input  logic [DLY_W-1:0]  dly_cfg,
  input  logic [WAKE_N-1:0] wake_evt,
  output logic              clk_en_cpu,
  output logic              clk_en_flash,
  output logic              clk_en_io,
  output logic              clk_en_adc,
  output logic              clk_en_async,
  output logic              osc_stop,
  output logic              adc_start
);

  slp_state_e state;
  slp_mode_e  mode_q;
  logic       wake_hit;
  logic       dly_load;
  logic       dly_done;
  logic       dly_run;

  assign dly_run = (state == S_DLY);

  slp_wake_filter i_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_evt (wake_evt),
    .mode_q   (mode_q),
    .wake_hit (wake_hit)
  );

  slp_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_en  (sleep_en),
    .sleep_req (sleep_req),
    .mode_sel  (mode_sel),
    .adc_on    (adc_on),
    .wake_hit  (wake_hit),
    .dly_done  (dly_done),
    .state     (state),
    .mode_q    (mode_q),
    .dly_load  (dly_load),
    .adc_start (adc_start)
  );

  slp_wake_timer #(
    .DLY_W        (DLY_W),
    .DLY_BASE_LOG (DLY_BASE_LOG)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (dly_load),
    .run     (dly_run),
    .dly_cfg (dly_cfg),
    .done    (dly_done)
  );

  slp_clk_decode i_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .mode_q       (mode_q),
    .clk_en_cpu   (clk_en_cpu),
    .clk_en_flash (clk_en_flash),
    .clk_en_io    (clk_en_io),
    .clk_en_adc   (clk_en_adc),
    .clk_en_async (clk_en_async),
    .osc_stop     (osc_stop)
  );

  // R10: the async timer keeps its clock whenever the oscillator is stopped in timer save
  assert_save_async_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && mode_q == M_SAVE) |-> clk_en_async);

endmodule

// File: tb/test_sleep_clock_ctrl.sv
module test_sleep_clock_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_en = 1'b0;
  logic       sleep_req = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       adc_on = 1'b0;
  logic [2:0] dly_cfg = 3'd0;
  logic [9:0] wake_evt = '0;
  logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_stop, adc_start;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sleep_clock_ctrl i_sleep_clock_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_req(sleep_req),
    .mode_sel(mode_sel), .adc_on(adc_on), .dly_cfg(dly_cfg), .wake_evt(wake_evt),
    .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
    .clk_en_adc(clk_en_adc), .clk_en_async(clk_en_async), .osc_stop(osc_stop),
    .adc_start(adc_start)
  );

  // gate vector: {cpu, flash, io, adc, async, osc_stop}
  localparam logic [5:0] G_RUN   = 6'b111110;
  localparam logic [5:0] G_LIGHT = 6'b001110;
  localparam logic [5:0] G_QUIET = 6'b000110;
  localparam logic [5:0] G_DEEP  = 6'b000001;
  localparam logic [5:0] G_SAVE  = 6'b000011;
  localparam logic [5:0] G_DDLY  = 6'b000000;
  localparam logic [5:0] G_SDLY  = 6'b000010;

  function automatic logic [5:0] gates();
    return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_stop};
  endfunction

  function automatic int delay_of(int cfg);
    return 4 * (2 ** cfg);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic request(logic [2:0] code, logic arm);
    @(negedge clk);
    sleep_en  = arm;
    mode_sel  = code;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic fire(int bitn);
    @(negedge clk);
    wake_evt[bitn] = 1'b1;
    @(negedge clk);
    wake_evt = '0;
  endtask

  task automatic t_reset();
    check("reset gates", 32'(gates()), 32'(G_RUN));
    check("reset adc_start", 32'(adc_start), 0);
  endtask

  task automatic t_unarmed();
    adc_on = 1'b1;
    request(3'b000, 1'b0);
    check("R1 gates", 32'(gates()), 32'(G_RUN));
    check("R1 adc_start", 32'(adc_start), 0);
    @(negedge clk);
    check("R1 still running", 32'(gates()), 32'(G_RUN));
  endtask

  task automatic t_light();
    adc_on = 1'b1;
    request(3'b000, 1'b1);
    check("R2 gates", 32'(gates()), 32'(G_LIGHT));
    check("R6 start on light entry", 32'(adc_start), 1);
    @(negedge clk);
    check("R6 single cycle", 32'(adc_start), 0);
    fire(0);
    check("R3 R13 generic irq wakes", 32'(gates()), 32'(G_RUN));
    sleep_en = 1'b0;
  endtask

  task automatic t_quiet();
    adc_on = 1'b1;
    request(3'b001, 1'b1);
    check("R4 gates", 32'(gates()), 32'(G_QUIET));
    check("R6 start on quiet entry", 32'(adc_start), 1);
    fire(0);
    check("R5 generic irq ignored", 32'(gates()), 32'(G_QUIET));
    fire(7);
    check("R5 R13 memory ready wakes", 32'(gates()), 32'(G_RUN));
    sleep_en = 1'b0;
  endtask

  task automatic t_deep();
    adc_on  = 1'b1;
    dly_cfg = 3'd0;
    request(3'b010, 1'b1);
    check("R7 gates", 32'(gates()), 32'(G_DEEP));
    check("R6 no start in deep", 32'(adc_start), 0);
    foreach (wake_evt[i]) begin
      if (i == 0 || i == 1 || i == 6 || i == 7) begin
        fire(i);
        check($sformatf("R8 bit %0d ignored", i), 32'(gates()), 32'(G_DEEP));
      end
    end
    fire(5);
    check("R9 delay begins, osc on", 32'(gates()), 32'(G_DDLY));
    repeat (delay_of(0) - 1) @(negedge clk);
    check("R9 still gated at last delay cycle", 32'(gates()), 32'(G_DDLY));
    @(negedge clk);
    check("R9 released after 4 cycles", 32'(gates()), 32'(G_RUN));
    sleep_en = 1'b0;
  endtask

  task automatic t_save();
    dly_cfg = 3'd2;
    request(3'b011, 1'b1);
    check("R10 gates", 32'(gates()), 32'(G_SAVE));
    fire(6);
    check("R10 timer irq wakes", 32'(gates()), 32'(G_SDLY));
    repeat (delay_of(2) - 1) @(negedge clk);
    check("R9 R10 gated at cycle 15", 32'(gates()), 32'(G_SDLY));
    @(negedge clk);
    check("R9 released after 16 cycles", 32'(gates()), 32'(G_RUN));
    sleep_en = 1'b0;
  endtask

  task automatic t_unlisted();
    adc_on = 1'b1;
    request(3'b110, 1'b1);
    check("R11 gates as light", 32'(gates()), 32'(G_LIGHT));
    check("R11 start as light", 32'(adc_start), 1);
    fire(0);
    check("R11 generic irq wakes, no delay", 32'(gates()), 32'(G_RUN));
    adc_on = 1'b0;
    request(3'b101, 1'b1);
    check("R11 R6 no start with adc off", 32'(adc_start), 0);
    fire(1);
    check("R11 conversion done wakes", 32'(gates()), 32'(G_RUN));
    sleep_en = 1'b0;
  endtask

  task automatic t_level();
    dly_cfg = 3'd0;
    request(3'b010, 1'b1);
    fire(8);
    check("R12 one-cycle level ignored", 32'(gates()), 32'(G_DEEP));
    @(negedge clk);
    check("R12 still asleep", 32'(gates()), 32'(G_DEEP));
    wake_evt[8] = 1'b1;
    @(negedge clk);
    check("R12 first edge not accepted", 32'(gates()), 32'(G_DEEP));
    @(negedge clk);
    wake_evt = '0;
    check("R12 held level wakes", 32'(gates()), 32'(G_DDLY));
    repeat (delay_of(0)) @(negedge clk);
    check("R12 R9 released", 32'(gates()), 32'(G_RUN));
    request(3'b010, 1'b1);
    fire(9);
    check("R8 lower ext line wakes", 32'(gates()), 32'(G_DDLY));
    repeat (delay_of(0)) @(negedge clk);
    sleep_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_light();
    t_quiet();
    t_deep();
    t_save();
    t_unlisted();
    t_level();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule